// File: doc/BRIEF.md
# Addressed Asynchronous Serial Receiver

This block turns a single asynchronous serial line into a stream of received telegrams. A free-running enable pulse at sixteen times the bit rate paces it. Each telegram is framed by a start bit and one or two stop bits. Its data field is seven or eight bits long and is sent least significant bit first. An optional odd or even parity bit may follow the data. A configuration bit can invert the line, which lets the receiver sit behind an inverting transceiver.

Each data field is compared with a programmable compare value. The data and four status bits leave the block together as one entry of a small first-in first-out queue. The status bits are parity error, frame error, break and address match. A receive-busy flag covers the span of each telegram. One-cycle strobes mark the end of each telegram, each break and each address match, so a controller can raise interrupts from them.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, `rx_busy`, `rcvd_stb`, `brk_stb`, `adr_stb` and `fifo_full` are 0 and `fifo_empty` is 1.
- R2: Data bits are taken least significant first. With `cfg_eight_bits`=0 only seven bits are received and `fifo_data[7]` reads 0.
- R3: With `cfg_parity_en`=1, a parity bit follows the data. `fifo_status[0]` (parity error) is set when the number of ones in the data plus the parity bit is even while `cfg_parity_odd`=1, or odd while `cfg_parity_odd`=0. With parity disabled, the bit reads 0.
- R4: With `cfg_two_stop`=1, two stop bits are expected, otherwise one. `fifo_status[1]` (frame error) is set when any stop bit samples low.
- R5: When every bit sampled in a telegram is low (data, parity and all stop bits), `fifo_status[2]` (break) is set and `brk_stb` pulses once.
- R6: `fifo_status[3]` is set and `adr_stb` pulses when the received data (zero-extended in 7-bit mode) equals `cfg_cmp_addr`, unless the same telegram has a parity or frame error.
- R7: `rcvd_stb` pulses once at the end of every telegram, even when the queue is full. A telegram that arrives while the queue is full is discarded, and the entries already stored stay unchanged.
- R8: `rx_busy` rises when a start edge is detected and falls when the telegram ends or its start is rejected.
- R9: A low pulse shorter than half a bit period is not taken as a start bit: no strobe fires and nothing is queued.
- R10: With `cfg_invert`=1, the line is inverted before framing, so idle is a low pin level.
- R11: The queue returns entries in arrival order. `fifo_data` and `fifo_status` always show the oldest entry, and `fifo_pop` removes it.
- R12: After a telegram ends, a new start is accepted only once the line has been seen idle. A line held low for longer than a telegram therefore yields exactly one telegram.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| rx_pin | input | 1 | Serial input line |
| cfg_invert | input | 1 | Invert the serial line |
| cfg_eight_bits | input | 1 | 1: eight data bits, 0: seven |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_cmp_addr | input | 8 | Compare value for address match |
| fifo_pop | input | 1 | Remove the oldest queued entry |
| fifo_empty | output | 1 | Queue is empty |
| fifo_full | output | 1 | Queue is full |
| fifo_data | output | 8 | Data of the oldest entry |
| fifo_status | output | 4 | Status of the oldest entry: {addr, brk, ferr, perr} |
| rx_busy | output | 1 | Telegram in progress |
| rcvd_stb | output | 1 | End-of-telegram strobe |
| brk_stb | output | 1 | Break strobe |
| adr_stb | output | 1 | Address-match strobe |

## Verification
The bench uses the default parameters: 16 oversampling ticks per bit and a four-entry queue. Five back-to-back telegrams are therefore enough to fill the queue and reach the overflow case. Running one tick per clock keeps a telegram at about two hundred cycles. This makes it affordable to sweep all 256 data values and also every combination of data width, parity mode and stop count, each with corrupted parity and a low stop bit. A slower tick spacing checks that the receiver depends on the tick and not on the clock. Inversion, glitch rejection and a held-low break are exercised as separate scenarios.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic addr;
    logic brk;
    logic ferr;
    logic perr;
  } rx_status_t;

  localparam int STAT_W = $bits(rx_status_t);

  // Parity check: odd mode needs an odd total of ones over data and parity bit.
  function automatic logic calc_perr(input logic [DATA_W-1:0] d,
                                     input logic pbit,
                                     input logic odd);
    return ((^d) ^ pbit) != odd;
  endfunction

  // A 7-bit field ends one position high in the shift register.
  function automatic logic [DATA_W-1:0] align_data(input logic [DATA_W-1:0] sh,
                                                   input logic eight);
    return eight ? sh : {1'b0, sh[DATA_W-1:1]};
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic invert,
  output logic line
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b1;
      q2 <= 1'b1;
    end else begin
      q1 <= pin;
      q2 <= q1;
    end
  end

  assign line = q2 ^ invert;
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              cfg_eight,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic [DATA_W-1:0] cfg_cmp,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] data_o,
  output rx_status_t        status_o,
  output logic              glitch_rej
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t               state;
  logic [CW-1:0]     cnt;
  logic [2:0]        bit_idx;
  logic              stop_idx;
  logic [DATA_W-1:0] shreg;
  logic              any_high, ferr_acc, par_bit, armed;

  logic              bit_tick, start_mid, last_stop, end_ev;
  logic [2:0]        last_idx;
  logic [DATA_W-1:0] fin_data;
  rx_status_t        fin_stat;

  assign bit_tick   = tick && (cnt == LAST);
  assign start_mid  = tick && (cnt == MID);
  assign last_idx   = cfg_eight ? 3'd7 : 3'd6;
  assign last_stop  = !cfg_two_stop || stop_idx;
  assign glitch_rej = (state == S_START) && start_mid && line;
  assign end_ev     = (state == S_STOP) && bit_tick && last_stop;

  always_comb begin
    fin_data      = align_data(shreg, cfg_eight);
    fin_stat.perr = cfg_par_en && calc_perr(fin_data, par_bit, cfg_par_odd);
    fin_stat.ferr = ferr_acc || !line;
    fin_stat.brk  = !(any_high || line);
    fin_stat.addr = (fin_data == cfg_cmp) && !fin_stat.perr && !fin_stat.ferr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      stop_idx <= 1'b0;
      shreg    <= '0;
      any_high <= 1'b0;
      ferr_acc <= 1'b0;
      par_bit  <= 1'b0;
      armed    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      data_o   <= '0;
      status_o <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (tick) begin
            if (line) begin
              armed <= 1'b1;
            end else if (armed) begin
              state    <= S_START;
              cnt      <= '0;
              busy     <= 1'b1;
              any_high <= 1'b0;
              ferr_acc <= 1'b0;
              par_bit  <= 1'b0;
            end
          end
        end
        S_START: begin
          if (start_mid) begin
            cnt <= '0;
            if (line) begin
              state <= S_IDLE;
              busy  <= 1'b0;
            end else begin
              state   <= S_DATA;
              bit_idx <= '0;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (tick) cnt <= bit_tick ? '0 : cnt + 1'b1;
          if (bit_tick) begin
            shreg    <= {line, shreg[DATA_W-1:1]};
            any_high <= any_high || line;
            bit_idx  <= bit_idx + 1'b1;
            stop_idx <= 1'b0;
            if (bit_idx == last_idx) state <= cfg_par_en ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          if (tick) cnt <= bit_tick ? '0 : cnt + 1'b1;
          if (bit_tick) begin
            par_bit  <= line;
            any_high <= any_high || line;
            state    <= S_STOP;
          end
        end
        S_STOP: begin
          if (tick) cnt <= bit_tick ? '0 : cnt + 1'b1;
          if (bit_tick) begin
            if (!last_stop) begin
              ferr_acc <= ferr_acc || !line;
              any_high <= any_high || line;
              stop_idx <= 1'b1;
            end else begin
              state    <= S_IDLE;
              busy     <= 1'b0;
              armed    <= 1'b0;
              done     <= 1'b1;
              data_o   <= fin_data;
              status_o <= fin_stat;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(line) == 1'b0);
  p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || $past(glitch_rej)));
  p_adr_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status_o.addr) |-> (!status_o.perr && !status_o.ferr));
  p_brk_ferr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status_o.brk) |-> status_o.ferr);
  p_end_from_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(end_ev));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   CNT_MAX = (AW + 1)'(DEPTH);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_MAX);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == PTR_MAX) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PTR_MAX) ? '0 : rp + 1'b1;
      count <= count + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == CNT_MAX));
  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX);
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_pin,
  input  logic              cfg_invert,
  input  logic              cfg_eight_bits,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_two_stop,
  input  logic [7:0]        cfg_cmp_addr,
  input  logic              fifo_pop,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic [7:0]        fifo_data,
  output logic [3:0]        fifo_status,
  output logic              rx_busy,
  output logic              rcvd_stb,
  output logic              brk_stb,
  output logic              adr_stb
);
  localparam int ENTRY_W = DATA_W + STAT_W;

  logic              line, done, glitch_rej;
  logic [DATA_W-1:0] rx_data;
  rx_status_t        rx_stat;
  logic [ENTRY_W-1:0] head;

  uart_rx_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin(rx_pin), .invert(cfg_invert), .line(line)
  );

  uart_rx_framer #(.OVS(OVS)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line),
    .cfg_eight(cfg_eight_bits), .cfg_par_en(cfg_parity_en),
    .cfg_par_odd(cfg_parity_odd), .cfg_two_stop(cfg_two_stop),
    .cfg_cmp(cfg_cmp_addr), .busy(rx_busy), .done(done),
    .data_o(rx_data), .status_o(rx_stat), .glitch_rej(glitch_rej)
  );

  uart_rx_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(done), .wdata({rx_stat, rx_data}),
    .pop(fifo_pop), .rdata(head), .empty(fifo_empty), .full(fifo_full)
  );

  assign fifo_data   = head[DATA_W-1:0];
  assign fifo_status = head[ENTRY_W-1:DATA_W];
  assign rcvd_stb    = done;
  assign brk_stb     = done && rx_stat.brk;
  assign adr_stb     = done && rx_stat.addr;

  p_strobe_sub_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_stb || adr_stb) |-> rcvd_stb);
  p_glitch_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_rej |-> !done);
endmodule

// File: tb/tb_uart_addr_rx.sv
`timescale 1ns/1ps
module tb_uart_addr_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rx_pin = 1'b1;
  logic cfg_invert = 1'b0, cfg_eight_bits = 1'b1, cfg_parity_en = 1'b0;
  logic cfg_parity_odd = 1'b0, cfg_two_stop = 1'b0;
  logic [7:0] cfg_cmp_addr = 8'h00;
  logic fifo_pop = 1'b0;
  logic fifo_empty, fifo_full, rx_busy, rcvd_stb, brk_stb, adr_stb;
  logic [7:0] fifo_data;
  logic [3:0] fifo_status;

  int checks = 0, fails = 0;
  int tdiv = 1, tcnt = 0;
  int n_rcvd = 0, n_brk = 0, n_adr = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_addr_rx dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_pin(rx_pin),
    .cfg_invert(cfg_invert), .cfg_eight_bits(cfg_eight_bits),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_cmp_addr(cfg_cmp_addr),
    .fifo_pop(fifo_pop), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_data(fifo_data), .fifo_status(fifo_status), .rx_busy(rx_busy),
    .rcvd_stb(rcvd_stb), .brk_stb(brk_stb), .adr_stb(adr_stb)
  );

  always @(negedge clk) begin
    if (tcnt >= tdiv - 1) begin tcnt <= 0; os_tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; os_tick <= 1'b0; end
    if (rst_n) begin
      if (rcvd_stb) n_rcvd <= n_rcvd + 1;
      if (brk_stb)  n_brk  <= n_brk + 1;
      if (adr_stb)  n_adr  <= n_adr + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic drive(input logic v, input int n);
    repeat (n) begin
      @(negedge clk);
      rx_pin = v ^ cfg_invert;
    end
  endtask

  task automatic pop1();
    @(negedge clk); fifo_pop = 1'b1;
    @(negedge clk); fifo_pop = 1'b0;
  endtask

  // Drives one telegram with the current configuration.
  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_low,
                            input bit chk_busy);
    int bl;
    logic [7:0] dm;
    logic pbit;
    bl = 16 * tdiv;
    dm = cfg_eight_bits ? d : {1'b0, d[6:0]};
    pbit = (^dm) ^ cfg_parity_odd ^ bad_par;
    drive(1'b0, 10 * tdiv);
    if (chk_busy) chk(rx_busy == 1'b1, "R8 busy in start bit", rx_busy, 1);
    drive(1'b0, bl - 10 * tdiv);
    for (int i = 0; i < (cfg_eight_bits ? 8 : 7); i++) drive(dm[i], bl);
    if (cfg_parity_en) drive(pbit, bl);
    if (cfg_two_stop) drive(1'b1, bl);
    drive(!stop_low, bl);
    drive(1'b1, 2 * bl);
  endtask

  // Sends one telegram and checks strobes and the queued entry.
  task automatic run_frame(input logic [7:0] d, input bit bad_par, input bit stop_low,
                           input bit full_chk);
    int r0, b0, a0;
    logic [7:0] dm;
    logic pbit, perr, ferr, brk, adr, anyh;
    logic [3:0] st;
    r0 = n_rcvd; b0 = n_brk; a0 = n_adr;
    dm = cfg_eight_bits ? d : {1'b0, d[6:0]};
    pbit = (^dm) ^ cfg_parity_odd ^ bad_par;
    perr = cfg_parity_en && bad_par;
    ferr = stop_low;
    anyh = (|dm) || (cfg_parity_en && pbit) || cfg_two_stop || !stop_low;
    brk = !anyh;
    adr = (dm == cfg_cmp_addr) && !perr && !ferr;
    st = {adr, brk, ferr, perr};
    send_frame(d, bad_par, stop_low, full_chk);
    chk(n_rcvd == r0 + 1, "R7 rcvd strobe", n_rcvd - r0, 1);
    chk(fifo_data == dm, "R2 data", fifo_data, dm);
    chk(fifo_status == st, "R3/R4/R6 status", fifo_status, st);
    if (full_chk) begin
      chk((n_brk - b0) == int'(brk), "R5 brk strobe", n_brk - b0, brk);
      chk((n_adr - a0) == int'(adr), "R6 adr strobe", n_adr - a0, adr);
      chk(rx_busy == 1'b0, "R8 busy cleared", rx_busy, 0);
    end
    pop1();
  endtask

  initial begin
    logic [7:0] vals [8];
    vals = '{8'h00, 8'hFF, 8'h55, 8'hA5, 8'h3C, 8'h7F, 8'h80, 8'h5A};
    repeat (3) @(negedge clk);
    chk(rx_busy == 0 && fifo_empty == 1 && fifo_full == 0, "R1 reset state",
        {rx_busy, fifo_empty, fifo_full}, 3'b010);
    chk(rcvd_stb == 0 && brk_stb == 0 && adr_stb == 0, "R1 strobes idle",
        {rcvd_stb, brk_stb, adr_stb}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // Exhaustive data sweep, 8 bits, even parity, one stop (R2, R3, R6)
    cfg_eight_bits = 1; cfg_parity_en = 1; cfg_parity_odd = 0; cfg_cmp_addr = 8'h5A;
    for (int v = 0; v < 256; v++) run_frame(8'(v), 1'b0, 1'b0, v < 4 || v == 8'h5A);

    // Configuration sweep (R2, R3, R4, R6)
    for (int c = 0; c < 12; c++) begin
      cfg_eight_bits = c[0];
      cfg_two_stop   = c[1];
      cfg_parity_en  = (c / 4) != 0;
      cfg_parity_odd = (c / 4) == 2;
      for (int k = 0; k < 8; k++) begin
        run_frame(vals[k], 1'b0, 1'b0, 1'b1);
        if (cfg_parity_en) run_frame(vals[k], 1'b1, 1'b0, 1'b1);
        run_frame(vals[k], 1'b0, 1'b1, 1'b1);
      end
    end

    // 7-bit mode address match with zero MSB (R2, R6)
    cfg_eight_bits = 0; cfg_parity_en = 0; cfg_two_stop = 0; cfg_cmp_addr = 8'h2B;
    run_frame(8'hAB, 1'b0, 1'b0, 1'b1);

    // Slower tick spacing
    tdiv = 3; cfg_eight_bits = 1; cfg_parity_en = 1; cfg_parity_odd = 1; cfg_cmp_addr = 8'hC3;
    repeat (10) @(negedge clk);
    run_frame(8'hC3, 1'b0, 1'b0, 1'b1);
    run_frame(8'h96, 1'b1, 1'b0, 1'b1);
    tdiv = 1;
    repeat (10) @(negedge clk);

    // Inverted line (R10)
    cfg_parity_en = 0; cfg_cmp_addr = 8'h81;
    @(negedge clk); cfg_invert = 1; rx_pin = 1'b0;
    repeat (60) @(negedge clk);
    run_frame(8'h81, 1'b0, 1'b0, 1'b1);
    run_frame(8'h4E, 1'b0, 1'b0, 1'b1);
    chk(fifo_empty == 1, "R10 no spurious entry", fifo_empty, 1);
    @(negedge clk); cfg_invert = 0; rx_pin = 1'b1;
    repeat (60) @(negedge clk);

    // Glitch rejection (R9)
    begin
      int r0;
      r0 = n_rcvd;
      drive(1'b0, 4);
      drive(1'b1, 400);
      chk(n_rcvd == r0, "R9 glitch no strobe", n_rcvd - r0, 0);
      chk(fifo_empty == 1, "R9 glitch not queued", fifo_empty, 1);
      chk(rx_busy == 0, "R9 busy after glitch", rx_busy, 0);
    end

    // Break with held-low line (R5, R6, R12)
    begin
      int r0, b0, a0;
      cfg_cmp_addr = 8'h00; cfg_eight_bits = 1; cfg_parity_en = 0; cfg_two_stop = 0;
      r0 = n_rcvd; b0 = n_brk; a0 = n_adr;
      drive(1'b0, 16 * 30);
      drive(1'b1, 16 * 3);
      chk(n_rcvd == r0 + 1, "R12 one telegram for long low", n_rcvd - r0, 1);
      chk(n_brk == b0 + 1, "R5 brk strobe", n_brk - b0, 1);
      chk(n_adr == a0, "R6 adr suppressed on ferr", n_adr - a0, 0);
      chk(fifo_status == 4'b0110, "R5 break status", fifo_status, 4'b0110);
      chk(fifo_data == 8'h00, "R5 break data", fifo_data, 0);
      pop1();
    end

    // Full queue (R7, R11)
    begin
      int r0;
      cfg_cmp_addr = 8'hEE;
      r0 = n_rcvd;
      for (int k = 0; k < 5; k++) send_frame(8'h10 + 8'(k), 1'b0, 1'b0, 1'b0);
      chk(n_rcvd == r0 + 5, "R7 strobe while full", n_rcvd - r0, 5);
      chk(fifo_full == 1, "R7 queue full", fifo_full, 1);
      for (int k = 0; k < 4; k++) begin
        chk(fifo_data == 8'h10 + 8'(k), "R11 order", fifo_data, 8'h10 + k);
        pop1();
      end
      chk(fifo_empty == 1, "R7 overflow entry dropped", fifo_empty, 1);
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule